// File: doc/BRIEF.md
# Quad-Output Serial Flash Burst Reader

This block is a host-side master that reads a run of consecutive bytes from a serial NOR flash. It uses the fast read transaction in which the reply comes back four bits wide. A caller pulses `startReq` with a 24-bit start address and a byte count. The block then pulls chip select low. It sends the read opcode and the address one bit per clock on data line 0, gives eight idle clocks so the lines can turn around, and then gathers one nibble per clock from all four data lines. Each finished byte leaves on a one-cycle `rdValid`/`rdData` strobe. The flash steps its own address after every byte, so a single transaction covers a burst of any length. Once the last byte is in, chip select rises and `done` pulses.

The serial clock runs at a fixed division of the system clock. It idles low. Outputs to the flash change on its falling edge, and read data is sampled on its rising edge. The four data lines reach the pads as separate out, output-enable and in vectors. A pad wrapper outside the block merges them into bidirectional pins.

Top module: `quad_read_master`

## Requirements
- R1: After chip select falls, the opcode 0x6B is presented on data line 0 over serial clocks 0 to 7, most significant bit first, and each bit is stable across its rising edge.
- R2: The 24-bit start address follows on data line 0 over serial clocks 8 to 31, bit 23 first.
- R3: Eight dummy clocks (32 to 39) follow the address. Read data starts at clock 40, and a transaction of N bytes holds exactly 40 + 2N rising serial-clock edges.
- R4: Each byte takes two clocks. In the first clock, line 3 carries bit 7 down to line 0 carrying bit 4. In the second clock the lines carry bits 3..0 in the same order. Bytes leave on `rdData` with a one-cycle `rdValid` in address order, starting at the requested address and wrapping from 0xFFFFFF to 0x000000.
- R5: Only output-enable bit 0 is ever set. It is high during serial clocks 0 to 31 and low from the falling edge that ends clock 31 until the end of the transaction.
- R6: The serial clock is low whenever chip select is high. While chip select is low, each half period lasts `HALF_DIV` system clocks, so rising edges are `2*HALF_DIV` system clocks apart.
- R7: Chip select goes low exactly once per non-empty request and rises after the last byte. `done` is high for one cycle at that point. `busy` is high from the cycle after the request until `done`.
- R8: A `startReq` that arrives while `busy` is high is ignored. The running burst keeps its address and count, and no second transaction follows.
- R9: A request with a byte count of zero gives a `done` pulse on the next cycle, with chip select held high and no bytes delivered.
- R10: During and right after reset, chip select is high, the serial clock is low, all output enables are low, and `busy`, `rdValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a burst |
| startAddr | input | 24 | First flash byte address |
| byteCount | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| rdValid | output | 1 | One-cycle strobe for `rdData` |
| rdData | output | 8 | Assembled read byte |
| done | output | 1 | One-cycle end-of-burst pulse |
| flashSclk | output | 1 | Serial clock to the flash |
| flashCsN | output | 1 | Active-low chip select |
| flashIoOut | output | 4 | Values driven onto data lines 3..0 |
| flashIoOe | output | 4 | Output enables for data lines 3..0 |
| flashIoIn | input | 4 | Values sampled from data lines 3..0 |

## Verification
The assertions assume that `startReq` is a single-cycle pulse, and that `startAddr` and `byteCount` are valid in that cycle. A zero-count request held over two cycles would produce two `done` cycles in a row. The bench's request task always raises `startReq` for exactly one system clock, at a falling clock edge. The flash model in the bench drives `flashIoIn` only on falling serial-clock edges inside the data phase, so the nibbles the block samples are always settled. The ignored-request case is the only one that issues a request while `busy` is high, which is the condition the block is meant to tolerate.

// File: rtl/quad_read_pkg.sv
package quad_read_pkg;

  localparam logic [7:0] READ_OPCODE = 8'h6B;
  localparam int OPCODE_CLKS = 8;
  localparam int ADDR_CLKS   = 24;
  localparam int DUMMY_CLKS  = 8;
  localparam int SEND_CLKS   = OPCODE_CLKS + ADDR_CLKS;
  localparam int DATA_START  = SEND_CLKS + DUMMY_CLKS;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;      // capture opcode and address into the shifter
    logic shift;     // advance the serial shifter (falling edge)
    logic sampleHi;  // take upper nibble (rising edge)
    logic sampleLo;  // take lower nibble and emit the byte
    logic driveIo0;  // enable the line 0 output driver
  } ctlStrobe_t;

endpackage

// File: rtl/quad_read_ctrl.sv
module quad_read_ctrl
  import quad_read_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             csN,
  output ctlStrobe_t       ctl
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int IDX_W = $clog2(DATA_START + 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] clkIdx;
  logic [CNT_W-1:0] remBytes;
  logic             nibLo;
  logic             sclkR, csNR, doneR;

  logic edgeNow, riseNow, fallNow, inData;

  assign edgeNow = (state == S_RUN) && (divCnt == DIV_W'(HALF_DIV - 1));
  assign riseNow = edgeNow && !sclkR;
  assign fallNow = edgeNow && sclkR;
  assign inData  = (clkIdx == IDX_W'(DATA_START));

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == S_IDLE) && startReq && (byteCount != '0);
    ctl.shift    = fallNow && !inData;
    ctl.sampleHi = riseNow && inData && !nibLo;
    ctl.sampleLo = riseNow && inData && nibLo;
    ctl.driveIo0 = (state == S_RUN) && (clkIdx < IDX_W'(SEND_CLKS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      clkIdx   <= '0;
      remBytes <= '0;
      nibLo    <= 1'b0;
      sclkR    <= 1'b0;
      csNR     <= 1'b1;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        S_IDLE: begin
          divCnt <= '0;
          if (startReq) begin
            if (byteCount == '0) begin
              doneR <= 1'b1;
            end else begin
              state    <= S_RUN;
              csNR     <= 1'b0;
              clkIdx   <= '0;
              remBytes <= byteCount;
              nibLo    <= 1'b0;
            end
          end
        end
        S_RUN: begin
          divCnt <= edgeNow ? '0 : DIV_W'(divCnt + 1'b1);
          if (riseNow) begin
            sclkR <= 1'b1;
            if (inData && nibLo) remBytes <= remBytes - 1'b1;
          end
          if (fallNow) begin
            sclkR <= 1'b0;
            if (inData) begin
              if (remBytes == '0) begin
                state <= S_IDLE;
                csNR  <= 1'b1;
                doneR <= 1'b1;
              end else begin
                nibLo <= !nibLo;
              end
            end else begin
              clkIdx <= IDX_W'(clkIdx + 1'b1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_RUN);
  assign done = doneR;
  assign sclk = sclkR;
  assign csN  = csNR;

  assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    csNR |-> !sclkR);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |=> (remBytes <= $past(remBytes)));

  assert_zero_no_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startReq && byteCount == '0) |=> (csNR && doneR));

endmodule

// File: rtl/quad_read_dp.sv
module quad_read_dp
  import quad_read_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  ctl,
  input  logic [23:0] startAddr,
  input  logic [3:0]  ioIn,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  output logic        rdValid,
  output logic [7:0]  rdData
);

  localparam int SHIFT_W = OPCODE_CLKS + ADDR_CLKS;

  logic [SHIFT_W-1:0] shiftReg;
  logic [3:0]         hiNib;
  logic               validR;
  logic [7:0]         dataR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiNib    <= '0;
      validR   <= 1'b0;
      dataR    <= '0;
    end else begin
      validR <= 1'b0;
      if (ctl.load)       shiftReg <= {READ_OPCODE, startAddr};
      else if (ctl.shift) shiftReg <= {shiftReg[SHIFT_W-2:0], 1'b0};
      if (ctl.sampleHi) hiNib <= ioIn;
      if (ctl.sampleLo) begin
        dataR  <= {hiNib, ioIn};
        validR <= 1'b1;
      end
    end
  end

  assign ioOut   = {3'b000, shiftReg[SHIFT_W-1]};
  assign ioOe    = {3'b000, ctl.driveIo0};
  assign rdValid = validR;
  assign rdData  = dataR;

  assert_byte_emitted_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleLo |=> validR);

  assert_released_when_sampling_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sampleHi || ctl.sampleLo) |-> !ctl.driveIo0);

endmodule

// File: rtl/quad_read_master.sv
module quad_read_master
  import quad_read_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [23:0]      startAddr,
  input  logic [CNT_W-1:0] byteCount,
  output logic             busy,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             flashSclk,
  output logic             flashCsN,
  output logic [3:0]       flashIoOut,
  output logic [3:0]       flashIoOe,
  input  logic [3:0]       flashIoIn
);

  ctlStrobe_t ctl;

  quad_read_ctrl #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .byteCount (byteCount),
    .busy      (busy),
    .done      (done),
    .sclk      (flashSclk),
    .csN       (flashCsN),
    .ctl       (ctl)
  );

  quad_read_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startAddr (startAddr),
    .ioIn      (flashIoIn),
    .ioOut     (flashIoOut),
    .ioOe      (flashIoOe),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

endmodule

// File: tb/test_quad_read_master.sv
module test_quad_read_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int CNT_W      = 16;
  localparam int NVEC       = 6;

  localparam logic [23:0] V_ADDR [NVEC] = '{24'h000000, 24'h12345F, 24'hABCDEF,
                                            24'h7FFFFE, 24'h0F0F0F, 24'hFFFFFE};
  localparam int          V_CNT  [NVEC] = '{4, 1, 7, 5, 16, 4};

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [23:0] startAddr = '0;
  logic [CNT_W-1:0] byteCount = '0;
  logic busy, rdValid, done, flashSclk, flashCsN;
  logic [7:0] rdData;
  logic [3:0] flashIoOut, flashIoOe, flashIoIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_read_master #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) i_quad_read_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .byteCount(byteCount), .busy(busy), .rdValid(rdValid), .rdData(rdData),
    .done(done), .flashSclk(flashSclk), .flashCsN(flashCsN),
    .flashIoOut(flashIoOut), .flashIoOe(flashIoOe), .flashIoIn(flashIoIn)
  );

  int nChecks = 0, nFail = 0;

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // ---- flash model ----
  int edgeCnt = 0, lastEdges = 0, oeViol = 0, kIdx;
  logic [7:0]  cmdCap = '0, bVal;
  logic [23:0] addrCap = '0;
  logic [3:0]  ioDrv = '0;
  assign flashIoIn = ioDrv;

  always @(posedge flashSclk or posedge flashCsN) begin
    if (flashCsN) begin
      if (edgeCnt != 0) lastEdges = edgeCnt;
      edgeCnt = 0;
    end else begin
      if (edgeCnt < 8)       cmdCap  = {cmdCap[6:0], flashIoOut[0]};
      else if (edgeCnt < 32) addrCap = {addrCap[22:0], flashIoOut[0]};
      if (flashIoOe[3:1] != 3'b000) oeViol++;
      if (edgeCnt < 32 && !flashIoOe[0]) oeViol++;
      if (edgeCnt >= 32 && flashIoOe[0]) oeViol++;
      edgeCnt++;
    end
  end

  always @(negedge flashSclk) begin
    if (!flashCsN && edgeCnt >= 40) begin
      kIdx  = edgeCnt - 40;
      bVal  = memByte(addrCap + 24'(kIdx / 2));
      ioDrv = (kIdx % 2 == 0) ? bVal[7:4] : bVal[3:0];
    end
  end

  // ---- output monitor ----
  int rxCnt = 0, doneCnt = 0, csFalls = 0, idleViol = 0, periodViol = 0;
  int cyc = 0, lastRise = -1;
  logic prevSclk = 1'b0;
  logic [7:0] rxBuf [64];

  always @(negedge flashCsN) csFalls++;

  always @(negedge clk) begin
    cyc++;
    if (rdValid) begin
      if (rxCnt < 64) rxBuf[rxCnt] = rdData;
      rxCnt++;
    end
    if (done) doneCnt++;
    if (flashCsN && flashSclk) idleViol++;
    if (flashCsN) lastRise = -1;
    else if (flashSclk && !prevSclk) begin
      if (lastRise >= 0 && cyc - lastRise != 2 * HALF_DIV) periodViol++;
      lastRise = cyc;
    end
    prevSclk = flashSclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startTx(input logic [23:0] a, input int n);
    rxCnt = 0; doneCnt = 0; oeViol = 0; idleViol = 0; periodViol = 0;
    @(negedge clk);
    startReq = 1'b1; startAddr = a; byteCount = CNT_W'(n);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 5000 && doneCnt == 0; i++) @(posedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkBurst(input logic [23:0] a, input int n, input int falls0);
    int bad = 0;
    check(cmdCap == 8'h6B, "R1", "opcode", cmdCap, 8'h6B);
    check(addrCap == a, "R2", "address", addrCap, a);
    check(lastEdges == 40 + 2 * n, "R3", "rising edges", lastEdges, 40 + 2 * n);
    check(rxCnt == n, "R4", "byte count", rxCnt, n);
    for (int i = 0; i < n && i < 64; i++) begin
      if (rxBuf[i] !== memByte(a + 24'(i))) begin
        bad++;
        check(1'b0, "R4", "byte value", rxBuf[i], memByte(a + 24'(i)));
      end
    end
    if (bad == 0) check(1'b1, "R4", "bytes", 0, 0);
    check(oeViol == 0, "R5", "output enable window", oeViol, 0);
    check(idleViol == 0 && periodViol == 0, "R6", "sclk idle/period",
          idleViol + periodViol, 0);
    check(doneCnt == 1, "R7", "done pulses", doneCnt, 1);
    check(csFalls - falls0 == 1 && flashCsN && !busy, "R7", "cs falls",
          csFalls - falls0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int falls0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(flashCsN && !flashSclk && flashIoOe == 4'h0 && !busy && !rdValid && !done,
          "R10", "during reset", {flashCsN, flashSclk, flashIoOe, busy, rdValid, done}, 9'h100);
    rstN = 1'b1;
    @(negedge clk);
    check(flashCsN && !flashSclk && flashIoOe == 4'h0 && !busy && !rdValid && !done,
          "R10", "after reset", {flashCsN, flashSclk, flashIoOe, busy, rdValid, done}, 9'h100);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      falls0 = csFalls;
      startTx(V_ADDR[v], V_CNT[v]);
      check(busy == 1'b1, "R7", "busy after request", busy, 1);
      waitDone();
      checkBurst(V_ADDR[v], V_CNT[v], falls0);
    end

    // R9: zero count
    falls0 = csFalls;
    startTx(24'h333333, 0);
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R9", "zero done", doneCnt, 1);
    check(csFalls == falls0 && rxCnt == 0 && !busy, "R9", "zero no cs",
          csFalls - falls0 + rxCnt, 0);

    // R8: request while busy is ignored
    falls0 = csFalls;
    startTx(24'h001000, 3);
    repeat (30) @(negedge clk);
    startReq = 1'b1; startAddr = 24'h555555; byteCount = CNT_W'(9);
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    checkBurst(24'h001000, 3, falls0);
    repeat (200) @(negedge clk);
    check(!busy && csFalls - falls0 == 1, "R8", "no second burst", csFalls - falls0, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule